// File: doc/BRIEF.md
# Camera Capture Decimation Front End

This block sits behind the pins of a parallel image sensor. It observes a pixel clock, a frame sync, a line sync and a pixel bus of up to 14 bits, all sampled by the system clock. On the selected pixel clock edge it takes one sample. It then decides through three independent filters whether the sample is kept: a frame-rate filter, a line odd/even filter and a per-item byte pattern. Kept samples are packed into 32-bit words, and each word goes to a downstream sink over a valid/ready handshake.

The sync levels define the picture. When the frame sync is at its active level, the sensor is between frames. When the line sync is at its active level, the sensor is between lines. Pixel data is valid only while both syncs are inactive. Capture is armed by a capture bit. In continuous mode the bit stays set and every frame that passes the rate filter is taken. In snapshot mode exactly one frame is taken and the bit then clears itself.

The block reports four events into a raw/enable/masked/clear set and drives one interrupt line.

Back-pressure rules: the output holds one word. While `out_valid` is high and `out_ready` is low, neither the word nor the valid flag changes. If a new word completes while the slot is still occupied, the new word is discarded and an overrun event is raised. There is no stall path toward the sensor.

Top module: `cam_decim_front`

## Requirements
- R1: A sample is taken on the pixel clock edge whose new level equals `ckpol` (1 selects rising, 0 selects falling). Each sync is active when its level equals its polarity input (1 means active high).
- R2: `width_sel` 0 takes `pix_in[7:0]` as a one-byte item. Codes 1, 2 and 3 take the low 10, 12 or 14 bits, zero-extended to 16, as a two-byte item with the low byte first.
- R3: `byte_sel` applies to item index k, which restarts at 0 on every line start. Code 0 keeps all items. Code 1 keeps k mod 2 = `byte_phase`. Code 2 keeps k mod 4 = `byte_phase`. Code 3 keeps items where (k - `byte_phase`) mod 4 is 0 or 1.
- R4: With `line_half` = 0 every line is kept. With `line_half` = 1, only lines whose index from frame start (first line is 0) has parity `line_phase` are kept.
- R5: The frame counter restarts while capture is off. `frame_rate` 0 (and 3) takes every frame. Code 1 takes frames 0, 2, 4 and so on. Code 2 takes frames 0, 4, 8 and so on.
- R6: Kept bytes are packed little-endian, with the first kept byte of each word in bits 7:0. A partial word at frame end is emitted with zero bytes in the unused positions.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: A word that completes while the slot is occupied and not being taken is discarded, the held word is kept, and the overrun event (bit 1) is raised.
- R9: In snapshot mode (`snap_mode` = 1), a `cap_set` pulse arms capture. The next whole frame is taken, `capture_on` clears at its end, and later frames are ignored.
- R10: In continuous mode `capture_on` stays set across frames. A `cap_clr` pulse before a frame start means that frame and the ones after it are not taken.
- R11: Event bit 0 fires at the end of a captured frame. Bit 2 fires on every inactive-to-active frame sync transition. Bit 3 fires at the end of each kept line of a captured frame.
- R12: `ev_raw` bits are set by their events and cleared by a 1 on the matching `ev_clr` bit. `ev_masked` is `ev_raw` AND `ev_en`, and `irq` is high when any masked bit is set.
- R13: `fifo_ne` shows an occupied output slot. `between_frames` and `between_lines` show the sampled sync states, and both read 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; when low no samples are taken |
| pclk_in | input | 1 | Sensor pixel clock (sampled) |
| vsync_in | input | 1 | Frame sync from the sensor |
| hsync_in | input | 1 | Line sync from the sensor |
| pix_in | input | DW (14) | Pixel data bus |
| ckpol | input | 1 | Sampling edge: 1 rising, 0 falling |
| vspol | input | 1 | Frame sync active level |
| hspol | input | 1 | Line sync active level |
| width_sel | input | 2 | Sample width: 8, 10, 12, 14 bits |
| byte_sel | input | 2 | Item keep pattern |
| byte_phase | input | 1 | Item pattern phase |
| line_half | input | 1 | Keep one line in two |
| line_phase | input | 1 | Parity of kept lines |
| frame_rate | input | 2 | Frame keep ratio |
| snap_mode | input | 1 | 1 snapshot, 0 continuous |
| cap_set | input | 1 | Pulse: set capture bit |
| cap_clr | input | 1 | Pulse: clear capture bit |
| capture_on | output | 1 | Capture bit state |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 32 | Packed output word |
| ev_en | input | 4 | Event enables |
| ev_clr | input | 4 | Event clear pulses |
| ev_raw | output | 4 | Raw event flags: 0 frame end, 1 overrun, 2 frame sync, 3 line |
| ev_masked | output | 4 | Raw AND enable |
| irq | output | 1 | OR of masked flags |
| fifo_ne | output | 1 | Output slot occupied |
| between_frames | output | 1 | Frame sync currently active |
| between_lines | output | 1 | Line sync currently active |

## Verification
The overrun is the hardest case to reach. It needs one completed word held in the output slot while a second and a third word finish behind it, and the discarded words must leave no trace in the stream. The stimulus holds `out_ready` low for a whole 12-byte frame. The scoreboard is told to expect only the first word of that frame. Once `out_ready` is released, the bench confirms that the single held word drains, the overrun flag is set and the slot reads empty.

The second hard case is a line start that falls on the same sample as its first data item. The frame task produces this shape on every line, so the item index and the line keep decision must both take effect on that sample.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam logic [1:0] BSEL_ALL    = 2'd0;
  localparam logic [1:0] BSEL_HALF   = 2'd1;
  localparam logic [1:0] BSEL_QUART  = 2'd2;
  localparam logic [1:0] BSEL_TWO4   = 2'd3;

  localparam logic [1:0] FRATE_ALL   = 2'd0;
  localparam logic [1:0] FRATE_HALF  = 2'd1;
  localparam logic [1:0] FRATE_QUART = 2'd2;

  localparam int EV_FRAME = 0;
  localparam int EV_OVR   = 1;
  localparam int EV_VSYNC = 2;
  localparam int EV_LINE  = 3;
  localparam int EV_NUM   = 4;

  // number of payload bits a width code selects
  function automatic int width_bits(input logic [1:0] code);
    return 8 + 2 * int'(code);
  endfunction
endpackage

// File: rtl/cam_sync_front.sv
module cam_sync_front #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pclk_in,
  input  logic          vs_in,
  input  logic          hs_in,
  input  logic [DW-1:0] din,
  input  logic          ckpol,
  input  logic          vspol,
  input  logic          hspol,
  output logic          stb,
  output logic          vs_act,
  output logic          hs_act,
  output logic [DW-1:0] dout
);
  logic          s_pclk, s_pclk_d, s_vs, s_hs;
  logic [DW-1:0] s_din;
  logic          edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pclk   <= 1'b0;
      s_pclk_d <= 1'b0;
      s_vs     <= 1'b0;
      s_hs     <= 1'b0;
      s_din    <= '0;
    end else begin
      s_pclk   <= pclk_in;
      s_pclk_d <= s_pclk;
      s_vs     <= vs_in;
      s_hs     <= hs_in;
      s_din    <= din;
    end
  end

  assign edge_hit = en && (s_pclk != s_pclk_d) && (s_pclk == ckpol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb    <= 1'b0;
      vs_act <= 1'b1;
      hs_act <= 1'b1;
      dout   <= '0;
    end else begin
      stb <= edge_hit;
      if (edge_hit) begin
        vs_act <= (s_vs == vspol);
        hs_act <= (s_hs == hspol);
        dout   <= s_din;
      end
    end
  end

  // R1: one sample per pixel clock edge, never back to back
  a_r1_strobe_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/cam_decimator.sv
module cam_decimator
  import cam_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stb,
  input  logic          vs_act,
  input  logic          hs_act,
  input  logic [DW-1:0] din,
  input  logic [1:0]    width,
  input  logic [1:0]    bsel,
  input  logic          bphase,
  input  logic          lhalf,
  input  logic          lphase,
  input  logic [1:0]    frate,
  input  logic          snap,
  input  logic          cap_set,
  input  logic          cap_clr,
  output logic          push,
  output logic          push_wide,
  output logic [15:0]   push_data,
  output logic          flush,
  output logic          fclear,
  output logic          ev_vsync,
  output logic          ev_line,
  output logic          ev_frame,
  output logic          capture_on
);
  logic       vs_q, hs_q;
  logic       in_frame, line_kept, line_par, capture_q;
  logic [1:0] item_cnt, frame_cnt;
  logic       vs_rise, vs_fall, hs_rise, hs_fall;
  logic       frame_keep, start_keep, cur_in_frame, line_start;
  logic       cur_par, calc_kept, cur_kept, data_slot, item_keep;
  logic [1:0] cur_item;
  logic [15:0] din16;

  assign vs_rise = stb && !vs_q && vs_act;
  assign vs_fall = stb && vs_q && !vs_act;
  assign hs_rise = stb && !hs_q && hs_act;
  assign hs_fall = stb && hs_q && !hs_act;

  always_comb begin
    unique case (frate)
      FRATE_HALF:  frame_keep = (frame_cnt[0] == 1'b0);
      FRATE_QUART: frame_keep = (frame_cnt == 2'd0);
      default:     frame_keep = 1'b1;
    endcase
  end

  assign start_keep   = capture_q && frame_keep;
  assign cur_in_frame = vs_fall ? start_keep : in_frame;
  assign line_start   = hs_fall || vs_fall;
  assign cur_par      = vs_fall ? 1'b0 : line_par;
  assign calc_kept    = !lhalf || (cur_par == lphase);
  assign cur_kept     = line_start ? calc_kept : line_kept;
  assign cur_item     = line_start ? 2'd0 : item_cnt;
  assign data_slot    = stb && !vs_act && !hs_act;

  always_comb begin
    unique case (bsel)
      BSEL_ALL:   item_keep = 1'b1;
      BSEL_HALF:  item_keep = (cur_item[0] == bphase);
      BSEL_QUART: item_keep = (cur_item == {1'b0, bphase});
      default:    item_keep = ((cur_item - {1'b0, bphase}) < 2'd2);
    endcase
  end

  assign din16 = 16'(din);

  always_comb begin
    push_data = '0;
    if (width == 2'd0) begin
      push_data[7:0] = din16[7:0];
    end else begin
      for (int b = 0; b < 16; b++) begin
        if (b < width_bits(width)) push_data[b] = din16[b];
      end
    end
  end

  assign push_wide = (width != 2'd0);
  assign push      = data_slot && cur_in_frame && cur_kept && item_keep;
  assign flush     = vs_rise && in_frame;
  assign fclear    = vs_fall;
  assign ev_vsync  = vs_rise;
  assign ev_frame  = vs_rise && in_frame;
  assign ev_line   = hs_rise && !vs_act && in_frame && line_kept;
  assign capture_on = capture_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q      <= 1'b1;
      hs_q      <= 1'b1;
      in_frame  <= 1'b0;
      line_kept <= 1'b0;
      line_par  <= 1'b0;
      item_cnt  <= '0;
    end else if (!en) begin
      in_frame <= 1'b0;
    end else if (stb) begin
      vs_q <= vs_act;
      hs_q <= hs_act;
      if (vs_fall) begin
        in_frame <= start_keep;
        line_par <= 1'b0;
      end else if (vs_rise) begin
        in_frame <= 1'b0;
      end else if (hs_rise && !vs_act) begin
        line_par <= ~line_par;
      end
      if (line_start) line_kept <= cur_kept;
      if (data_slot)       item_cnt <= cur_item + 2'd1;
      else if (line_start) item_cnt <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capture_q <= 1'b0;
      frame_cnt <= '0;
    end else begin
      if (cap_set) capture_q <= 1'b1;
      else if (cap_clr) capture_q <= 1'b0;
      else if (ev_frame && snap) capture_q <= 1'b0;

      if (!capture_q) frame_cnt <= '0;
      else if (vs_fall) frame_cnt <= frame_cnt + 2'd1;
    end
  end

  // R9: a snapshot frame ending drops the capture bit
  a_r9_snapshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame && snap && !cap_set) |=> !capture_on);
  // R11: no frame-end event unless a frame sync rise is seen
  a_r11_frame_on_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |-> ev_vsync);
  // R10: capture bit stays set without a clear or a snapshot end
  a_r10_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_on && !cap_clr && !snap) |=> capture_on);
endmodule

// File: rtl/cam_packer.sv
module cam_packer #(
  parameter int WB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            wide,
  input  logic [15:0]     pdata,
  input  logic            flush,
  input  logic            clear,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [8*WB-1:0] out_data,
  output logic            ovr
);
  localparam int CW = $clog2(WB);
  localparam int WW = 8 * WB;

  logic [CW-1:0] bcnt;
  logic [WW-1:0] acc, base_acc, merged;
  int            base_cnt, fill;
  logic          word_done, slot_free;

  always_comb begin
    base_acc = clear ? '0 : acc;
    base_cnt = clear ? 0 : int'(bcnt);
    merged   = base_acc;
    for (int b = 0; b < WB; b++) begin
      if (push && b == base_cnt) merged[b*8 +: 8] = pdata[7:0];
      if (push && wide && b == base_cnt + 1) merged[b*8 +: 8] = pdata[15:8];
    end
    fill      = base_cnt + (push ? (wide ? 2 : 1) : 0);
    word_done = (fill >= WB) || (flush && fill != 0);
  end

  assign slot_free = !out_valid || out_ready;
  assign ovr       = word_done && !slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (word_done) begin
        acc  <= '0;
        bcnt <= '0;
      end else begin
        acc  <= merged;
        bcnt <= CW'(fill);
      end
      if (word_done && slot_free) begin
        out_data  <= merged;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: a stalled word holds
  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8: an overrun keeps the word already offered
  a_r8_ovr_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/cam_irq_bank.sv
module cam_irq_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw[i] <= 1'b0;
      else if (set[i]) raw[i] <= 1'b1;
      else if (clr[i]) raw[i] <= 1'b0;
    end

    // R12: a clear with no new event empties the flag
    a_r12_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !raw[i]);
    // R12: an event always leaves its flag set
    a_r12_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> raw[i]);
  end

  assign masked = raw & en;
  assign irq    = |masked;
endmodule

// File: rtl/cam_decim_front.sv
module cam_decim_front
  import cam_pkg::*;
#(
  parameter int DW         = 14,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    pclk_in,
  input  logic                    vsync_in,
  input  logic                    hsync_in,
  input  logic [DW-1:0]           pix_in,
  input  logic                    ckpol,
  input  logic                    vspol,
  input  logic                    hspol,
  input  logic [1:0]              width_sel,
  input  logic [1:0]              byte_sel,
  input  logic                    byte_phase,
  input  logic                    line_half,
  input  logic                    line_phase,
  input  logic [1:0]              frame_rate,
  input  logic                    snap_mode,
  input  logic                    cap_set,
  input  logic                    cap_clr,
  output logic                    capture_on,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [8*WORD_BYTES-1:0] out_data,
  input  logic [EV_NUM-1:0]       ev_en,
  input  logic [EV_NUM-1:0]       ev_clr,
  output logic [EV_NUM-1:0]       ev_raw,
  output logic [EV_NUM-1:0]       ev_masked,
  output logic                    irq,
  output logic                    fifo_ne,
  output logic                    between_frames,
  output logic                    between_lines
);
  logic          stb, vs_act, hs_act;
  logic [DW-1:0] sdat;
  logic          push, push_wide, flush, fclear;
  logic [15:0]   push_data;
  logic          ev_vsync, ev_line, ev_frame, ovr;
  logic [EV_NUM-1:0] ev_set;

  cam_sync_front #(.DW(DW)) u_front (
    .clk(clk), .rst_n(rst_n), .en(en),
    .pclk_in(pclk_in), .vs_in(vsync_in), .hs_in(hsync_in), .din(pix_in),
    .ckpol(ckpol), .vspol(vspol), .hspol(hspol),
    .stb(stb), .vs_act(vs_act), .hs_act(hs_act), .dout(sdat)
  );

  cam_decimator #(.DW(DW)) u_decim (
    .clk(clk), .rst_n(rst_n), .en(en),
    .stb(stb), .vs_act(vs_act), .hs_act(hs_act), .din(sdat),
    .width(width_sel), .bsel(byte_sel), .bphase(byte_phase),
    .lhalf(line_half), .lphase(line_phase), .frate(frame_rate),
    .snap(snap_mode), .cap_set(cap_set), .cap_clr(cap_clr),
    .push(push), .push_wide(push_wide), .push_data(push_data),
    .flush(flush), .fclear(fclear),
    .ev_vsync(ev_vsync), .ev_line(ev_line), .ev_frame(ev_frame),
    .capture_on(capture_on)
  );

  cam_packer #(.WB(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wide(push_wide), .pdata(push_data),
    .flush(flush), .clear(fclear), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .ovr(ovr)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EV_FRAME] = ev_frame;
    ev_set[EV_OVR]   = ovr;
    ev_set[EV_VSYNC] = ev_vsync;
    ev_set[EV_LINE]  = ev_line;
  end

  cam_irq_bank #(.N(EV_NUM)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set(ev_set), .en(ev_en), .clr(ev_clr),
    .raw(ev_raw), .masked(ev_masked), .irq(irq)
  );

  assign fifo_ne        = out_valid;
  assign between_frames = vs_act;
  assign between_lines  = hs_act;

  // R13: no word can leave the slot while the sink refuses it
  a_r13_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ne && !out_ready) |=> fifo_ne);
endmodule

// File: tb/sim_cam_decim_front.sv
module sim_cam_decim_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        en = 1'b1, pclk_in = 1'b0, vsync_in = 1'b1, hsync_in = 1'b1;
  logic [13:0] pix_in = '0;
  logic        ckpol = 1'b1, vspol = 1'b1, hspol = 1'b1;
  logic [1:0]  width_sel = 2'd0, byte_sel = 2'd0, frame_rate = 2'd0;
  logic        byte_phase = 1'b0, line_half = 1'b0, line_phase = 1'b0;
  logic        snap_mode = 1'b0, cap_set = 1'b0, cap_clr = 1'b0;
  logic        capture_on, out_valid, out_ready, irq, fifo_ne, between_frames, between_lines;
  logic [31:0] out_data;
  logic [3:0]  ev_en = 4'h0, ev_clr = 4'h0, ev_raw, ev_masked;

  cam_decim_front u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pclk_in(pclk_in), .vsync_in(vsync_in),
    .hsync_in(hsync_in), .pix_in(pix_in), .ckpol(ckpol), .vspol(vspol), .hspol(hspol),
    .width_sel(width_sel), .byte_sel(byte_sel), .byte_phase(byte_phase),
    .line_half(line_half), .line_phase(line_phase), .frame_rate(frame_rate),
    .snap_mode(snap_mode), .cap_set(cap_set), .cap_clr(cap_clr), .capture_on(capture_on),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ev_en(ev_en), .ev_clr(ev_clr), .ev_raw(ev_raw), .ev_masked(ev_masked), .irq(irq),
    .fifo_ne(fifo_ne), .between_frames(between_frames), .between_lines(between_lines)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R6";
  logic [31:0] expq[$];
  logic [31:0] wacc;
  int wcnt, nwords;
  bit ovr_mode = 0;
  int rdy_mode = 0;   // 0 ready high, 1 ready low, 2 toggling
  bit hold_chk = 0;
  logic [31:0] held;

  // sink ready driver
  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) out_ready = 1'b1;
    else if (rdy_mode == 1) out_ready = 1'b0;
    else out_ready = ~out_ready;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_chk) begin
        n_chk++;
        if (!out_valid || out_data !== held) begin
          n_bad++;
          $display("FAIL R7 held word actual=%h/%b expected=%h/1", out_data, out_valid, held);
        end
      end
      if (out_valid && out_ready) begin
        n_chk++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL %s extra word actual=%h expected=none", cur_req, out_data);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          if (out_data !== e) begin
            n_bad++;
            $display("FAIL %s word actual=%h expected=%h", cur_req, out_data, e);
          end
        end
      end
      hold_chk = out_valid && !out_ready;
      held     = out_data;
    end
  end

  function automatic bit item_ok(input int k);
    case (byte_sel)
      2'd0: return 1'b1;
      2'd1: return (k % 2) == int'(byte_phase);
      2'd2: return (k % 4) == int'(byte_phase);
      default: return ((k + 4 - int'(byte_phase)) % 4) < 2;
    endcase
  endfunction

  task automatic model_byte(input logic [7:0] b);
    wacc[wcnt*8 +: 8] = b;
    wcnt++;
    if (wcnt == 4) begin
      if (!ovr_mode || nwords == 0) expq.push_back(wacc);
      nwords++;
      wacc = '0;
      wcnt = 0;
    end
  endtask

  task automatic px(input bit va, input bit ha, input logic [13:0] d);
    @(posedge clk); #1;
    pclk_in  = ~ckpol;
    vsync_in = va ? vspol : ~vspol;
    hsync_in = ha ? hspol : ~hspol;
    pix_in   = d;
    repeat (3) @(posedge clk);
    #1 pclk_in = ckpol;
    repeat (2) @(posedge clk);
  endtask

  task automatic run_frame(input int nl, input int ni, input int base, input bit kept);
    wacc = '0; wcnt = 0; nwords = 0;
    px(1, 1, 0); px(1, 1, 0);
    px(0, 1, 0);
    for (int l = 0; l < nl; l++) begin
      for (int k = 0; k < ni; k++) begin
        logic [13:0] d;
        d = 14'(base + l * ni + k);
        px(0, 0, d);
        if (l == 0 && k == 1) begin
          @(negedge clk);
          chk("R13 mid-line between_lines", {31'b0, between_lines}, 0);
          chk("R13 mid-frame between_frames", {31'b0, between_frames}, 0);
        end
        if (kept && (!line_half || (l % 2) == int'(line_phase)) && item_ok(k)) begin
          if (width_sel == 2'd0) model_byte(d[7:0]);
          else begin
            logic [15:0] v;
            v = 16'(d) & 16'((32'd1 << (8 + 2 * int'(width_sel))) - 1);
            model_byte(v[7:0]);
            model_byte(v[15:8]);
          end
        end
      end
      px(0, 1, 0);
    end
    if (wcnt != 0) begin
      if (!ovr_mode || nwords == 0) expq.push_back(wacc);
      wcnt = 0;
    end
    px(1, 1, 0); px(1, 1, 0);
  endtask

  task automatic drain(input string req);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk({req, " all words delivered"}, expq.size(), 0);
  endtask

  task automatic pulse_set();
    @(posedge clk); #1 cap_set = 1'b1;
    @(posedge clk); #1 cap_set = 1'b0;
  endtask

  task automatic pulse_clr();
    @(posedge clk); #1 cap_clr = 1'b1;
    @(posedge clk); #1 cap_clr = 1'b0;
  endtask

  task automatic clear_ev();
    @(posedge clk); #1 ev_clr = 4'hF;
    @(posedge clk); #1 ev_clr = 4'h0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset fifo_ne", {31'b0, fifo_ne}, 0);
    chk("R13 reset between_frames", {31'b0, between_frames}, 1);
    chk("R13 reset between_lines", {31'b0, between_lines}, 1);
    chk("R12 reset raw", {28'b0, ev_raw}, 0);
    chk("R12 reset irq", {31'b0, irq}, 0);
    chk("R9 reset capture", {31'b0, capture_on}, 0);

    // basic 8-bit continuous capture
    ev_en = 4'hF;
    cur_req = "R6";
    pulse_set();
    run_frame(2, 6, 'h10, 1);
    drain("R6");
    chk("R11 frame event", {31'b0, ev_raw[0]}, 1);
    chk("R11 frame sync event", {31'b0, ev_raw[2]}, 1);
    chk("R11 line event", {31'b0, ev_raw[3]}, 1);
    chk("R12 irq with enables", {31'b0, irq}, 1);
    chk("R10 capture stays on", {31'b0, capture_on}, 1);
    ev_en = 4'b0010;
    @(negedge clk);
    chk("R12 masked is raw and enable", {28'b0, ev_masked}, 0);
    chk("R12 irq follows mask", {31'b0, irq}, 0);
    ev_en = 4'hF;
    clear_ev();
    chk("R12 clear empties raw", {28'b0, ev_raw}, 0);

    // 12-bit items, upper bits masked
    cur_req = "R2";
    width_sel = 2'd2;
    run_frame(2, 3, 'h3F80, 1);
    drain("R2");
    width_sel = 2'd0;

    // byte patterns
    cur_req = "R3";
    byte_sel = 2'd1; byte_phase = 1'b1;
    run_frame(1, 8, 'h40, 1);
    drain("R3 every other");
    byte_sel = 2'd2; byte_phase = 1'b0;
    cur_req = "R3 R6 pad";
    run_frame(1, 8, 'h50, 1);
    drain("R3 one of four");
    byte_sel = 2'd3; byte_phase = 1'b1;
    cur_req = "R3";
    run_frame(2, 8, 'h60, 1);
    drain("R3 two of four");
    byte_sel = 2'd0; byte_phase = 1'b0;

    // line decimation
    cur_req = "R4";
    line_half = 1'b1; line_phase = 1'b1;
    run_frame(3, 4, 'h80, 1);
    drain("R4 odd lines");
    line_phase = 1'b0;
    run_frame(3, 4, 'h90, 1);
    drain("R4 even lines");
    line_half = 1'b0;

    // polarity and edge
    cur_req = "R1";
    ckpol = 1'b0; vspol = 1'b0; hspol = 1'b0;
    run_frame(2, 4, 'hA0, 1);
    drain("R1");
    ckpol = 1'b1; vspol = 1'b1; hspol = 1'b1;
    run_frame(1, 4, 'hB0, 1);
    drain("R1 restored");

    // frame rate
    cur_req = "R5";
    pulse_clr();
    frame_rate = 2'd1;
    pulse_set();
    run_frame(1, 4, 'h11, 1);
    clear_ev();
    run_frame(1, 4, 'h22, 0);
    @(negedge clk);
    chk("R11 no frame event on skipped frame", {31'b0, ev_raw[0]}, 0);
    chk("R11 frame sync on skipped frame", {31'b0, ev_raw[2]}, 1);
    chk("R11 no line event on skipped frame", {31'b0, ev_raw[3]}, 0);
    run_frame(1, 4, 'h33, 1);
    drain("R5 alternate");
    pulse_clr();
    frame_rate = 2'd2;
    pulse_set();
    run_frame(1, 4, 'h44, 1);
    run_frame(1, 4, 'h55, 0);
    run_frame(1, 4, 'h66, 0);
    run_frame(1, 4, 'h77, 0);
    run_frame(1, 4, 'h88, 1);
    drain("R5 one of four");
    frame_rate = 2'd0;

    // back-pressure with toggling ready
    cur_req = "R7";
    clear_ev();
    rdy_mode = 2;
    width_sel = 2'd3;
    run_frame(2, 6, 'h2F00, 1);
    drain("R7");
    chk("R7 no overrun while draining", {31'b0, ev_raw[1]}, 0);
    width_sel = 2'd0;
    rdy_mode = 0;

    // overrun
    cur_req = "R8";
    rdy_mode = 1;
    ovr_mode = 1;
    run_frame(1, 12, 'hC0, 1);
    @(negedge clk);
    chk("R8 overrun flag", {31'b0, ev_raw[1]}, 1);
    chk("R13 slot occupied", {31'b0, fifo_ne}, 1);
    rdy_mode = 0;
    drain("R8");
    ovr_mode = 0;
    chk("R13 slot empty after drain", {31'b0, fifo_ne}, 0);

    // snapshot
    cur_req = "R9";
    pulse_clr();
    snap_mode = 1'b1;
    pulse_set();
    @(negedge clk);
    chk("R9 armed", {31'b0, capture_on}, 1);
    run_frame(1, 8, 'hD0, 1);
    @(negedge clk);
    chk("R9 capture self-cleared", {31'b0, capture_on}, 0);
    clear_ev();
    run_frame(1, 8, 'hE0, 0);
    drain("R9");
    chk("R9 no frame event after snapshot", {31'b0, ev_raw[0]}, 0);
    snap_mode = 1'b0;

    // continuous stop
    cur_req = "R10";
    pulse_set();
    run_frame(1, 4, 'hF0, 1);
    run_frame(1, 4, 'hF4, 1);
    pulse_clr();
    run_frame(1, 4, 'hF8, 0);
    drain("R10");
    @(negedge clk);
    chk("R10 capture off after clear", {31'b0, capture_on}, 0);

    finish_run();
  end
endmodule